// File: doc/BRIEF.md
# Serial Link Mode Detector

This block sits at the front of a slave-only serial host port. It watches the bits that an external master clocks in on the data-in line while the active-low select is held low, and it recognises one of three start-up patterns. A matching pattern latches a link mode and fires a single-cycle internal reset that the rest of the port uses to clear its state. The two SPI flavours are chosen by sixteen identical bits. The 9-bit clocked serial mode is chosen by a run of exactly nine zeros followed by a word of seven ones and one free last bit. The block never drives the serial clock and never starts a transfer.

The serial clock, data and select pins are brought into the system clock domain through synchronisers. A data bit is taken on each synchronised rising serial-clock edge while select is low. The master owns the serial clock, so the port has no valid/ready pair and cannot apply back-pressure. The system clock must run fast enough to see every serial-clock level, which means at least four system cycles per serial half period with the default two synchroniser stages. The mode output and its valid flag are plain registered status. A match restarts detection at once, so the host may send a new initialization pattern at any later time.

Top module: `link_mode_detect`

## Requirements
- R1: After reset, mode_o is 2'b00, mode_vld_o is 0 and init_rst_o is 0. mode_vld_o is 1 exactly when mode_o is not 2'b00.
- R2: Sixteen consecutive 0 bits received in one select window set mode_o to 2'b01 (SPI variant A) and raise mode_vld_o.
- R3: Sixteen consecutive 1 bits received in one select window set mode_o to 2'b10 (SPI variant B).
- R4: Exactly nine 0 bits followed by the eight bits 1111_1111 (first bit received first) set mode_o to 2'b11 (9-bit serial mode).
- R5: The last bit of the 9-bit mode word is free, so nine 0 bits followed by 1111_1110 also select 2'b11.
- R6: Each completed match produces exactly one init_rst_o pulse of one system clock cycle, in the same cycle as the new mode_o value appears.
- R7: Raising ss_n during a partial pattern discards it. Bits sent before the rise do not count toward a later match.
- R8: A stream that matches no pattern leaves mode_vld_o low. On a mismatched bit the search restarts with that bit counted as the first bit of a new pattern. A zero run of 10 to 15 bits followed by a 1 does not select the 9-bit mode.
- R9: After a mode is latched, a further valid pattern, including one in the same select window, issues a new pulse and may switch to a different mode.
- R10: Serial clock edges that occur while ss_n is high have no effect.
- R11: mode_o changes only in a cycle where init_rst_o is high, and mode_vld_o stays high once set until system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| mosi | input | 1 | Serial data from the master, asynchronous |
| ss_n | input | 1 | Active-low slave select, asynchronous |
| mode_o | output | 2 | Latched link mode: 00 none, 01 SPI A, 10 SPI B, 11 9-bit serial |
| mode_vld_o | output | 1 | A link mode has been latched |
| init_rst_o | output | 1 | One-cycle internal reset pulse on each match |

## Verification
The detector is driven with each of the three start patterns and with both forms of the 9-bit mode word. Together these show that the zero-run length separates SPI A from the 9-bit mode and that the free last bit is honoured. Near-miss streams are also sent: a ten-to-fifteen zero run before a 1, a mode word broken by a 0, and a pattern split by a select rise. These separate a true match from partial counting and show that the search restarts correctly. A leading run of ones before sixteen zeros shows that the offending bit restarts the search. Back-to-back patterns in one window, together with clock edges sent while deselected, show that the mode can be switched and that idle clocks are ignored.

// File: rtl/smd_pkg.sv
package smd_pkg;
  typedef enum logic [1:0] {
    LINK_NONE  = 2'b00,
    LINK_SPI_A = 2'b01,
    LINK_SPI_B = 2'b10,
    LINK_SCI9  = 2'b11
  } link_mode_e;

  typedef enum logic [1:0] {
    CAND_IDLE,
    CAND_ZERO,
    CAND_ONE,
    CAND_NINE
  } cand_e;
endpackage

// File: rtl/smd_sync.sv
module smd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rst_val,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= rst_val;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/smd_sampler.sv
module smd_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic mosi,
  input  logic ss_n,
  output logic bit_vld,
  output logic bit_val,
  output logic sel_act
);
  logic [2:0] raw;
  logic [2:0] synced;
  logic       sclk_prev;

  assign raw = {ss_n, sclk, mosi};

  smd_sync #(.WIDTH(3), .STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (3'b100),
    .d       (raw),
    .q       (synced)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= synced[1];
  end

  assign sel_act = ~synced[2];
  assign bit_val = synced[0];
  assign bit_vld = synced[1] & ~sclk_prev & sel_act;
endmodule

// File: rtl/smd_matcher.sv
module smd_matcher
  import smd_pkg::*;
#(
  parameter int WORD_BITS     = 8,
  parameter int SCI_WORD_BITS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       bit_vld,
  input  logic       bit_val,
  output logic       hit,
  output link_mode_e hit_mode
);
  localparam int SPI_LEN = 2 * WORD_BITS;
  localparam int SCI_LEN = SCI_WORD_BITS + WORD_BITS;
  localparam int CW      = $clog2(SCI_LEN + 1);

  cand_e          cand_q, cand_n;
  logic [CW-1:0]  cnt_q, cnt_n;

  always_comb begin
    cand_n   = cand_q;
    cnt_n    = cnt_q;
    hit      = 1'b0;
    hit_mode = LINK_NONE;
    if (clr) begin
      cand_n = CAND_IDLE;
      cnt_n  = '0;
    end else if (bit_vld) begin
      unique case (cand_q)
        CAND_IDLE: begin
          cand_n = bit_val ? CAND_ONE : CAND_ZERO;
          cnt_n  = CW'(1);
        end
        CAND_ZERO: begin
          if (!bit_val) begin
            if (cnt_q == CW'(SPI_LEN - 1)) begin
              hit = 1'b1; hit_mode = LINK_SPI_A;
              cand_n = CAND_IDLE; cnt_n = '0;
            end else cnt_n = cnt_q + CW'(1);
          end else if (cnt_q == CW'(SCI_WORD_BITS)) begin
            cand_n = CAND_NINE; cnt_n = cnt_q + CW'(1);
          end else begin
            cand_n = CAND_ONE; cnt_n = CW'(1);
          end
        end
        CAND_ONE: begin
          if (bit_val) begin
            if (cnt_q == CW'(SPI_LEN - 1)) begin
              hit = 1'b1; hit_mode = LINK_SPI_B;
              cand_n = CAND_IDLE; cnt_n = '0;
            end else cnt_n = cnt_q + CW'(1);
          end else begin
            cand_n = CAND_ZERO; cnt_n = CW'(1);
          end
        end
        CAND_NINE: begin
          if (cnt_q == CW'(SCI_LEN - 1)) begin
            hit = 1'b1; hit_mode = LINK_SCI9;
            cand_n = CAND_IDLE; cnt_n = '0;
          end else if (bit_val) begin
            cnt_n = cnt_q + CW'(1);
          end else begin
            cand_n = CAND_ZERO; cnt_n = CW'(1);
          end
        end
        default: begin
          cand_n = CAND_IDLE; cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= CAND_IDLE;
      cnt_q  <= '0;
    end else begin
      cand_q <= cand_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/link_mode_detect.sv
module link_mode_detect
  import smd_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int WORD_BITS     = 8,
  parameter int SCI_WORD_BITS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       ss_n,
  output logic [1:0] mode_o,
  output logic       mode_vld_o,
  output logic       init_rst_o
);
  logic       bit_vld, bit_val, sel_act, hit;
  link_mode_e hit_mode, mode_q;

  smd_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .mosi    (mosi),
    .ss_n    (ss_n),
    .bit_vld (bit_vld),
    .bit_val (bit_val),
    .sel_act (sel_act)
  );

  smd_matcher #(.WORD_BITS(WORD_BITS), .SCI_WORD_BITS(SCI_WORD_BITS)) u_matcher (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (~sel_act),
    .bit_vld  (bit_vld),
    .bit_val  (bit_val),
    .hit      (hit),
    .hit_mode (hit_mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= LINK_NONE;
      mode_vld_o <= 1'b0;
      init_rst_o <= 1'b0;
    end else begin
      init_rst_o <= hit;
      if (hit) begin
        mode_q     <= hit_mode;
        mode_vld_o <= 1'b1;
      end
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/link_mode_detect_chk.sv
module link_mode_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic       mode_vld_o,
  input logic       init_rst_o
);
  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_rst_o |=> !init_rst_o);

  // R6
  pulse_sets_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_rst_o |-> mode_vld_o);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_rst_o |-> (mode_o == $past(mode_o)));

  // R11
  vld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_vld_o |=> mode_vld_o);

  // R1
  vld_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_vld_o == (mode_o != 2'b00));
endmodule

bind link_mode_detect link_mode_detect_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_o     (mode_o),
  .mode_vld_o (mode_vld_o),
  .init_rst_o (init_rst_o)
);

// File: tb/link_mode_detect_bench.sv
module link_mode_detect_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       ss_n = 1'b1;
  logic [1:0] mode_o;
  logic       mode_vld_o;
  logic       init_rst_o;

  int total = 0;
  int bad   = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  logic       prev_rst = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  link_mode_detect u_link_mode_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .mosi       (mosi),
    .ss_n       (ss_n),
    .mode_o     (mode_o),
    .mode_vld_o (mode_vld_o),
    .init_rst_o (init_rst_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_mode(input logic [1:0] m, input string req);
    exp_q.push_back(m);
    tag_q.push_back(req);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    mosi = b;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
  endtask

  task automatic send_run(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic send_word(input logic [7:0] w);
    for (int i = 7; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic select(input logic v);
    @(negedge clk);
    ss_n = v;
    wait_clk(6);
  endtask

  task automatic drained(input string req);
    wait_clk(12);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // Monitor: pops expected modes as pulses appear
  always @(negedge clk) begin
    if (rst_n && init_rst_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected pulse", mode_o, 0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(mode_o == e && mode_vld_o, t, mode_o, e);
      end
      // R6 pulse lasts one cycle
      check(!prev_rst, "R6 pulse width", prev_rst, 0);
    end
    prev_rst <= init_rst_o;
  end

  initial begin
    wait_clk(5);
    // R1 reset values
    check(mode_o == 2'b00, "R1 mode", mode_o, 0);
    check(!mode_vld_o, "R1 vld", mode_vld_o, 0);
    check(!init_rst_o, "R1 pulse", init_rst_o, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // R8 near misses: 12 zeros then ones, 9 zeros then 0xF0
    select(1'b0);
    send_run(1'b0, 12);
    send_word(8'hFF);
    select(1'b1);
    select(1'b0);
    send_run(1'b0, 9);
    send_word(8'hF0);
    select(1'b1);
    wait_clk(10);
    check(!mode_vld_o, "R8 no match vld", mode_vld_o, 0);
    check(mode_o == 2'b00, "R8 no match mode", mode_o, 0);

    // R10 clocks while deselected
    send_run(1'b0, 16);
    wait_clk(10);
    check(!mode_vld_o, "R10 deselected clocks", mode_vld_o, 0);

    // R7 split pattern, then completed in the new window
    select(1'b0);
    send_run(1'b0, 10);
    select(1'b1);
    select(1'b0);
    send_run(1'b0, 6);
    wait_clk(10);
    check(!mode_vld_o, "R7 split not matched", mode_vld_o, 0);
    expect_mode(2'b01, "R7 R2 fresh zeros");
    send_run(1'b0, 10);
    drained("R2 spi A");
    select(1'b1);

    // R3 then R9 switch in the same window
    select(1'b0);
    expect_mode(2'b10, "R3 spi B");
    send_run(1'b1, 16);
    drained("R3 spi B");
    expect_mode(2'b11, "R4 R9 sci after B");
    send_run(1'b0, 9);
    send_word(8'hFF);
    drained("R4 sci");
    select(1'b1);

    // R5 free last bit
    select(1'b0);
    send_run(1'b1, 5);
    expect_mode(2'b01, "R8 restart R9 back to A");
    send_run(1'b0, 16);
    drained("R8 restart");
    expect_mode(2'b11, "R5 sci FE");
    send_run(1'b0, 9);
    send_word(8'hFE);
    drained("R5 sci FE");
    select(1'b1);

    // R11 mode held after a non-matching stream
    select(1'b0);
    send_run(1'b0, 11);
    send_word(8'hFF);
    select(1'b1);
    wait_clk(10);
    check(mode_o == 2'b11 && mode_vld_o, "R11 mode held", mode_o, 3);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule